// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns an addressing-mode code and an instruction operand field into the 16-bit effective address, the 8-bit operand value and the instruction length in bytes, for an 8-bit accumulator processor. A caller presents the mode, the 16-bit operand field and the current X, Y and accumulator contents together with a one-cycle start strobe. Modes that need no memory finish at once. Direct memory modes read one byte. Pointer modes first read a two-byte pointer and then the operand byte.

The unit owns a byte-wide read port with one cycle of read latency. The byte for the address driven in a cycle with the read enable high appears on the data input in the next cycle. Completion is a single-cycle done pulse. The address, value and length outputs are registered and change only in the cycle in which done is high.

Top module: `eagu_top`

## Requirements
- R1: The mode code on `mode_i` is 0 implied, 1 accumulator, 2 immediate, 3 relative, 4 zero page, 5 zero page X, 6 zero page Y, 7 absolute, 8 absolute X, 9 absolute Y, 10 indirect, 11 X-indexed indirect and 12 indirect Y-indexed. Codes 13 to 15 behave as implied. Modes 0 to 3 report address 0x0000 with no memory read. Their value is 0 for implied, the operand's low byte for immediate and relative, and `acc_i` for accumulator.
- R2: Absolute mode uses the operand as the address. Absolute X and absolute Y add the zero-extended index with a 16-bit sum that wraps at 0xFFFF.
- R3: Zero-page modes keep the operand's low byte, or the 8-bit sum of that byte and the index. The upper address byte is always 0x00.
- R4: Indirect mode reads the pointer low byte at the operand and the high byte at operand+1 (16-bit wrap). The address is high*256+low.
- R5: X-indexed indirect mode reads the pointer low byte at B = operand+X and the high byte at B+1. Both sums are 16-bit and wrap.
- R6: Indirect Y-indexed mode reads the pointer at operand and operand+1, then adds Y to the 16-bit pointer with 16-bit wrap.
- R7: For modes 4 to 12 the value is the memory byte at the effective address.
- R8: `len_o` is 3 for modes 7 to 9, 1 for modes 0, 1 and 13 to 15, and 2 otherwise.
- R9: Count the edge that samples an accepted start as edge 0. `done_o` is high for the cycle after edge 0 in modes 0 to 3 and 13 to 15, after edge 2 in modes 4 to 9, and after edge 5 in modes 10 to 12. At all other times it is low.
- R10: A start strobe that arrives while a request is in progress is ignored. The result matches the original request.
- R11: After reset `done_o`, `ea_o`, `val_o`, `len_o` and `mem_rd_o` are 0. The three result outputs change only in a cycle where `done_o` is high.
- R12: Reads use one-cycle latency. No read is issued while idle, and no done follows directly after a read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe |
| mode_i | input | 4 | Addressing mode code |
| opnd_i | input | 16 | Operand field |
| xr_i | input | 8 | X index register |
| yr_i | input | 8 | Y index register |
| acc_i | input | 8 | Accumulator |
| mem_rd_o | output | 1 | Memory read enable |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 8 | Read data, valid one cycle after the read |
| done_o | output | 1 | Completion pulse |
| ea_o | output | 16 | Effective address |
| val_o | output | 8 | Operand value |
| len_o | output | 2 | Instruction length in bytes |

## Verification
The assertions assume that the memory answers every read exactly one cycle later and that `mode_i` and the register inputs are steady at the clock edge where a start is sampled. The bench models the memory as a pure function of the address, registered on the read enable, so the port latency is always met. Stimulus changes only between edges. Strobes are deliberately placed inside busy windows, and operands sit at page and 0xFFFF boundaries.

// File: rtl/eagu_pkg.sv
package eagu_pkg;

    parameter int ADDR_W = 16;
    parameter int DATA_W = 8;
    parameter int MODE_W = 4;
    parameter int LEN_W  = 2;
    localparam int PAD_W = ADDR_W - DATA_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef enum logic [MODE_W-1:0] {
        AM_IMPL  = 4'd0,
        AM_ACC   = 4'd1,
        AM_IMM   = 4'd2,
        AM_REL   = 4'd3,
        AM_ZP    = 4'd4,
        AM_ZPX   = 4'd5,
        AM_ZPY   = 4'd6,
        AM_ABS   = 4'd7,
        AM_ABSX  = 4'd8,
        AM_ABSY  = 4'd9,
        AM_IND   = 4'd10,
        AM_XIND  = 4'd11,
        AM_INDY  = 4'd12,
        AM_RSV13 = 4'd13,
        AM_RSV14 = 4'd14,
        AM_RSV15 = 4'd15
    } am_e;

    typedef enum logic [1:0] {
        CL_REG    = 2'd0,
        CL_DIRECT = 2'd1,
        CL_PTR    = 2'd2
    } am_class_e;

    typedef struct packed {
        am_e   mode;
        addr_t opnd;
        byte_t xr;
        byte_t yr;
    } req_t;

    typedef struct packed {
        addr_t ea;
        byte_t val;
        len_t  len;
    } result_t;

    function automatic am_class_e am_class(input am_e m);
        case (m)
            AM_ZP, AM_ZPX, AM_ZPY, AM_ABS, AM_ABSX, AM_ABSY: return CL_DIRECT;
            AM_IND, AM_XIND, AM_INDY:                         return CL_PTR;
            default:                                          return CL_REG;
        endcase
    endfunction

    function automatic len_t am_len(input am_e m);
        case (m)
            AM_ABS, AM_ABSX, AM_ABSY:                               return len_t'(3);
            AM_IMPL, AM_ACC, AM_RSV13, AM_RSV14, AM_RSV15:          return len_t'(1);
            default:                                                return len_t'(2);
        endcase
    endfunction

    function automatic addr_t zext(input byte_t b);
        return {{PAD_W{1'b0}}, b};
    endfunction

    function automatic addr_t direct_ea(input req_t r);
        case (r.mode)
            AM_ABS:  return r.opnd;
            AM_ABSX: return r.opnd + zext(r.xr);
            AM_ABSY: return r.opnd + zext(r.yr);
            AM_ZP:   return zext(r.opnd[DATA_W-1:0]);
            AM_ZPX:  return zext(byte_t'(r.opnd[DATA_W-1:0] + r.xr));
            AM_ZPY:  return zext(byte_t'(r.opnd[DATA_W-1:0] + r.yr));
            default: return '0;
        endcase
    endfunction

    function automatic addr_t ptr_base(input req_t r);
        case (r.mode)
            AM_XIND: return r.opnd + zext(r.xr);
            default: return r.opnd;
        endcase
    endfunction

    function automatic byte_t reg_value(input am_e m, input addr_t op, input byte_t acc);
        case (m)
            AM_ACC:         return acc;
            AM_IMM, AM_REL: return op[DATA_W-1:0];
            default:        return '0;
        endcase
    endfunction

endpackage

// File: rtl/eagu_direct.sv
module eagu_direct
    import eagu_pkg::*;
(
    input  req_t  req,
    output addr_t ea,
    output addr_t ptr_lo_addr,
    output addr_t ptr_hi_addr
);
    addr_t base;

    always_comb begin
        base        = ptr_base(req);
        ea          = direct_ea(req);
        ptr_lo_addr = base;
        ptr_hi_addr = base + addr_t'(1);
    end
endmodule

// File: rtl/eagu_ptr.sv
module eagu_ptr
    import eagu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cap_lo,
    input  logic  cap_hi,
    input  byte_t rdata,
    input  logic  add_y,
    input  byte_t yr,
    output addr_t ea
);
    byte_t lo_q;
    byte_t hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (cap_lo) lo_q <= rdata;
            if (cap_hi) hi_q <= rdata;
        end
    end

    always_comb begin
        ea = {hi_q, lo_q};
        if (add_y) ea = ea + zext(yr);
    end
endmodule

// File: rtl/eagu_ctl.sv
module eagu_ctl
    import eagu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  am_class_e in_cls,
    output logic      accept,
    output logic      reg_done,
    output logic      busy,
    output logic      mem_rd,
    output logic      sel_plo,
    output logic      sel_phi,
    output logic      cap_lo,
    output logic      cap_hi,
    output logic      cap_op
);
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PLO  = 3'd1,
        ST_PHI  = 3'd2,
        ST_PCAP = 3'd3,
        ST_ORD  = 3'd4,
        ST_OCAP = 3'd5
    } st_e;

    st_e st_q;
    st_e st_d;

    always_comb begin
        accept   = (st_q == ST_IDLE) && start;
        reg_done = accept && (in_cls == CL_REG);
        st_d     = st_q;
        case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    case (in_cls)
                        CL_PTR:    st_d = ST_PLO;
                        CL_DIRECT: st_d = ST_ORD;
                        default:   st_d = ST_IDLE;
                    endcase
                end
            end
            ST_PLO:  st_d = ST_PHI;
            ST_PHI:  st_d = ST_PCAP;
            ST_PCAP: st_d = ST_ORD;
            ST_ORD:  st_d = ST_OCAP;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign busy    = (st_q != ST_IDLE);
    assign sel_plo = (st_q == ST_PLO);
    assign sel_phi = (st_q == ST_PHI);
    assign mem_rd  = sel_plo || sel_phi || (st_q == ST_ORD);
    assign cap_lo  = (st_q == ST_PHI);
    assign cap_hi  = (st_q == ST_PCAP);
    assign cap_op  = (st_q == ST_OCAP);
endmodule

// File: rtl/eagu_top.sv
module eagu_top
    import eagu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [ADDR_W-1:0] opnd_i,
    input  logic [DATA_W-1:0] xr_i,
    input  logic [DATA_W-1:0] yr_i,
    input  logic [DATA_W-1:0] acc_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              done_o,
    output logic [ADDR_W-1:0] ea_o,
    output logic [DATA_W-1:0] val_o,
    output logic [LEN_W-1:0]  len_o
);
    am_e       mode_in;
    am_class_e cls_in;
    req_t      req_q;
    result_t   res_q;
    logic      done_q;

    logic  accept, reg_done, busy, mem_rd, sel_plo, sel_phi;
    logic  cap_lo, cap_hi, cap_op;
    addr_t dir_ea, ptr_lo_a, ptr_hi_a, ptr_ea, op_addr;

    assign mode_in = am_e'(mode_i);
    assign cls_in  = am_class(mode_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (accept) begin
            req_q.mode <= mode_in;
            req_q.opnd <= opnd_i;
            req_q.xr   <= xr_i;
            req_q.yr   <= yr_i;
        end
    end

    eagu_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .in_cls   (cls_in),
        .accept   (accept),
        .reg_done (reg_done),
        .busy     (busy),
        .mem_rd   (mem_rd),
        .sel_plo  (sel_plo),
        .sel_phi  (sel_phi),
        .cap_lo   (cap_lo),
        .cap_hi   (cap_hi),
        .cap_op   (cap_op)
    );

    eagu_direct u_dir (
        .req         (req_q),
        .ea          (dir_ea),
        .ptr_lo_addr (ptr_lo_a),
        .ptr_hi_addr (ptr_hi_a)
    );

    eagu_ptr u_ptr (
        .clk    (clk),
        .rst    (rst),
        .cap_lo (cap_lo),
        .cap_hi (cap_hi),
        .rdata  (mem_rdata_i),
        .add_y  (req_q.mode == AM_INDY),
        .yr     (req_q.yr),
        .ea     (ptr_ea)
    );

    assign op_addr = (am_class(req_q.mode) == CL_PTR) ? ptr_ea : dir_ea;

    always_comb begin
        if (!mem_rd)      mem_addr_o = '0;
        else if (sel_plo) mem_addr_o = ptr_lo_a;
        else if (sel_phi) mem_addr_o = ptr_hi_a;
        else              mem_addr_o = op_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else if (reg_done) begin
            res_q.ea  <= '0;
            res_q.val <= reg_value(mode_in, opnd_i, acc_i);
            res_q.len <= am_len(mode_in);
            done_q    <= 1'b1;
        end else if (cap_op) begin
            res_q.ea  <= op_addr;
            res_q.val <= mem_rdata_i;
            res_q.len <= am_len(req_q.mode);
            done_q    <= 1'b1;
        end else begin
            done_q <= 1'b0;
        end
    end

    assign mem_rd_o = mem_rd;
    assign done_o   = done_q;
    assign ea_o     = res_q.ea;
    assign val_o    = res_q.val;
    assign len_o    = res_q.len;
endmodule

// File: rtl/eagu_chk.sv
module eagu_chk
    import eagu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [MODE_W-1:0] mode_i,
    input logic              busy,
    input logic              mem_rd_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              done_o,
    input logic [ADDR_W-1:0] ea_o,
    input logic [DATA_W-1:0] val_o,
    input logic [LEN_W-1:0]  len_o
);
    logic take, take_reg, take_zp, take_impl;

    assign take      = start_i && !busy;
    assign take_reg  = take && (am_class(am_e'(mode_i)) == CL_REG);
    assign take_zp   = take && (mode_i == AM_ZP || mode_i == AM_ZPX || mode_i == AM_ZPY);
    assign take_impl = take && (mode_i == AM_IMPL);

    p_reg_ea_r1: assert property (@(posedge clk) disable iff (rst)
        take_reg |=> (ea_o == '0));

    p_zp_page_r3: assert property (@(posedge clk) disable iff (rst)
        take_zp |=> (mem_rd_o && mem_addr_o[ADDR_W-1:DATA_W] == '0));

    p_impl_len_r8: assert property (@(posedge clk) disable iff (rst)
        take_impl |=> (len_o == LEN_W'(1) && val_o == '0));

    p_reg_done_r9: assert property (@(posedge clk) disable iff (rst)
        take_reg |=> done_o);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy);

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(ea_o) && $stable(val_o) && $stable(len_o)));

    p_idle_no_read_r12: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_rd_o);

    p_read_latency_r12: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |=> !done_o);
endmodule

bind eagu_top eagu_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .busy       (busy),
    .mem_rd_o   (mem_rd_o),
    .mem_addr_o (mem_addr_o),
    .done_o     (done_o),
    .ea_o       (ea_o),
    .val_o      (val_o),
    .len_o      (len_o)
);

// File: tb/test_eagu_top.sv
module test_eagu_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [3:0]  mode_i = '0;
    logic [15:0] opnd_i = '0;
    logic [7:0]  xr_i = '0, yr_i = '0, acc_i = '0;
    logic        mem_rd_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_rdata_i = '0;
    logic        done_o;
    logic [15:0] ea_o;
    logic [7:0]  val_o;
    logic [1:0]  len_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    bit run      = 0;

    always #5 clk = ~clk;

    eagu_top i_eagu_top (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .opnd_i(opnd_i), .xr_i(xr_i), .yr_i(yr_i), .acc_i(acc_i),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
        .done_o(done_o), .ea_o(ea_o), .val_o(val_o), .len_o(len_o)
    );

    function automatic int mem_byte(input int a);
        return ((a * 37) + ((a >> 8) * 11) + 5) & 255;
    endfunction

    always @(posedge clk) if (mem_rd_o) mem_rdata_i <= 8'(mem_byte(int'(mem_addr_o)));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // reference model state
    int  m_cnt = 0, m_mode = 0, h_ea = 0, h_val = 0, h_len = 0;
    int  p_ea = 0, p_val = 0, p_len = 0;
    bit  m_busy = 0, m_done = 0, m_dropped = 0, d_dropped = 0;

    task automatic model_calc(input int md, input int op, input int x, input int y, input int a,
                              output int ea, output int val, output int len, output int lat);
        int b;
        int ptr;
        val = 0;
        case (md)
            1: begin ea = 0; val = a; end
            2, 3: begin ea = 0; val = op & 255; end
            4: ea = op & 255;
            5: ea = (op + x) & 255;
            6: ea = (op + y) & 255;
            7: ea = op;
            8: ea = (op + x) & 16'hFFFF;
            9: ea = (op + y) & 16'hFFFF;
            10: ea = mem_byte(op) + 256 * mem_byte((op + 1) & 16'hFFFF);
            11: begin
                b  = (op + x) & 16'hFFFF;
                ea = mem_byte(b) + 256 * mem_byte((b + 1) & 16'hFFFF);
            end
            12: begin
                ptr = mem_byte(op) + 256 * mem_byte((op + 1) & 16'hFFFF);
                ea  = (ptr + y) & 16'hFFFF;
            end
            default: ea = 0;
        endcase
        if (md >= 4 && md <= 12) val = mem_byte(ea);
        if (md >= 7 && md <= 9) len = 3;
        else if (md <= 1 || md >= 13) len = 1;
        else len = 2;
        if (md >= 4 && md <= 9) lat = 2;
        else if (md >= 10 && md <= 12) lat = 5;
        else lat = 0;
    endtask

    always @(posedge clk) begin
        int lat;
        if (rst) begin
            m_busy = 0; m_cnt = 0; m_done = 0; m_dropped = 0;
            h_ea = 0; h_val = 0; h_len = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (start_i) m_dropped = 1;
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1; d_dropped = m_dropped;
                    h_ea = p_ea; h_val = p_val; h_len = p_len;
                end
            end else if (start_i) begin
                m_mode = int'(mode_i);
                m_dropped = 0;
                model_calc(m_mode, int'(opnd_i), int'(xr_i), int'(yr_i), int'(acc_i),
                           p_ea, p_val, p_len, lat);
                if (lat == 0) begin
                    m_done = 1; d_dropped = 0;
                    h_ea = p_ea; h_val = p_val; h_len = p_len;
                end else begin
                    m_busy = 1; m_cnt = lat;
                end
            end
        end
    end

    function automatic string ea_tag(input int md);
        if (md <= 3 || md >= 13) return "R1 ea";
        if (md >= 7 && md <= 9)  return "R2 ea";
        if (md >= 4 && md <= 6)  return "R3 ea";
        if (md == 10)            return "R4 ea";
        if (md == 11)            return "R5 ea";
        return "R6 ea";
    endfunction

    always @(negedge clk) begin
        if (run && !rst) begin
            if (m_mode >= 4 && m_mode <= 12)
                check(done_o == m_done, "R9 R12 done timing", int'(done_o), int'(m_done));
            else
                check(done_o == m_done, "R9 done timing", int'(done_o), int'(m_done));
            if (done_o && m_done) begin
                check(int'(ea_o) == h_ea, ea_tag(m_mode), int'(ea_o), h_ea);
                if (m_mode >= 4 && m_mode <= 12)
                    check(int'(val_o) == h_val, "R7 R12 value", int'(val_o), h_val);
                else
                    check(int'(val_o) == h_val, "R1 value", int'(val_o), h_val);
                check(int'(len_o) == h_len, "R8 length", int'(len_o), h_len);
                if (d_dropped)
                    check(int'(ea_o) == h_ea && int'(val_o) == h_val, "R10 busy start ignored",
                          int'(ea_o), h_ea);
            end else if (!done_o) begin
                check(int'(ea_o) == h_ea && int'(val_o) == h_val && int'(len_o) == h_len,
                      "R11 hold", int'(ea_o), h_ea);
            end
        end
    end

    task automatic issue(input int md, input int op, input int x, input int y, input int a, input int gap);
        @(negedge clk); #2;
        start_i = 1'b1; mode_i = 4'(md); opnd_i = 16'(op);
        xr_i = 8'(x); yr_i = 8'(y); acc_i = 8'(a);
        @(negedge clk); #2;
        start_i = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(done_o == 1'b0 && mem_rd_o == 1'b0, "R11 reset done/read", int'(done_o), 0);
        check(ea_o == '0 && val_o == '0 && len_o == '0, "R11 reset outputs", int'(ea_o), 0);
        #2 rst = 1'b0;
        run = 1;
        // R1 register-only modes
        issue(0, 16'h1234, 1, 2, 8'h77, 3);
        issue(1, 16'h1234, 1, 2, 8'hA5, 3);
        issue(2, 16'h12C3, 1, 2, 8'hA5, 3);
        issue(3, 16'h00FE, 1, 2, 8'hA5, 3);
        issue(14, 16'hBEEF, 1, 2, 8'hA5, 3);
        // back-to-back register-only requests
        issue(2, 16'h0011, 0, 0, 0, 0);
        issue(2, 16'h0022, 0, 0, 0, 3);
        // R2 absolute, carry and wrap
        issue(7, 16'h4321, 0, 0, 0, 5);
        issue(8, 16'h12F0, 8'h20, 0, 0, 5);
        issue(9, 16'hFFF0, 0, 8'h20, 0, 5);
        // R3 zero page wrap
        issue(4, 16'h1234, 0, 0, 0, 5);
        issue(5, 16'h00F0, 8'h20, 0, 0, 5);
        issue(6, 16'hABFF, 0, 8'h01, 0, 5);
        // R4 R5 R6 pointer modes at boundaries
        issue(10, 16'h20FF, 0, 0, 0, 8);
        issue(10, 16'hFFFF, 0, 0, 0, 8);
        issue(11, 16'hFFF0, 8'h0F, 0, 0, 8);
        issue(11, 16'h0080, 8'h90, 0, 0, 8);
        issue(12, 16'h0033, 0, 8'hFF, 0, 8);
        // R10 start during busy
        issue(10, 16'h0456, 0, 0, 0, 0);
        issue(2, 16'h0099, 0, 0, 0, 0);
        issue(7, 16'h0199, 0, 0, 0, 8);
        // mixed stream with random gaps
        for (int i = 0; i < 80; i++) begin
            issue(int'($urandom % 16), int'($urandom & 16'hFFFF), int'($urandom & 255),
                  int'($urandom & 255), int'($urandom & 255), int'($urandom % 7));
        end
        repeat (10) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule